// File: doc/BRIEF.md
# Supply-Watch and Wake Event Controller

This block gathers the events that should wake a host microcontroller next to a low-power radio transmitter, and it reports them on a single active-low request line. It checks a digital "supply is below threshold" comparator result only once per slow sample period, not on every clock. It also holds the 4-bit threshold code that sets the comparator trip point. A wake-up timer timeout pulse and a transmit-FIFO almost-empty pulse are merged with the low-supply result into sticky cause bits.

The host reacts to the request line. It reads the 4-bit status word through the serial status read, and the shifter raises a one-cycle strobe when that read completes. The strobe clears the cause bits. Each source has its own enable, so any unused function can be switched off. Switching off the supply detector also stops its sample timer.

Top module: `evtc_top`

## Requirements
- R1: After reset, irq_n is 1, status is 4'b0000 and thr_code is 4'd0, the lowest trip point.
- R2: When thr_wr is high at a clock edge, thr_code takes thr_wdata on that edge. Code N selects a trip point of base + N x 0.1 V at the external comparator. The code holds its value until the next write.
- R3: While det_en is high, a sample tick occurs once every SAMPLE_DIV clocks. The comparator input passes through a two-flop synchronizer. On each tick, status[3] takes the synchronized level (1 means the supply is below the threshold).
- R4: status[1] (low supply) is set only on a sample tick at which the synchronized level is 1. Comparator activity between ticks does not set it.
- R5: A low-supply condition that is still present after status[1] has been cleared is flagged again at the next sample tick and not before. While status[1] is pending, further ticks do not flag it again.
- R6: A wake_evt pulse sets status[0] only while wake_en is 1. A fifo_evt pulse sets status[2] only while fifo_en is 1. A pulse that arrives while its enable is 0 is ignored.
- R7: Cause bits status[2:0] are sticky. A stat_rd_done pulse clears them on the next edge. An event in the same cycle as the clear wins, so its bit stays set.
- R8: irq_n is 0 exactly when one of the cause bits is set and its own enable is high (bit 0 with wake_en, bit 1 with det_en, bit 2 with fifo_en). Dropping an enable releases irq_n, and the pending bit stays readable.
- R9: While det_en is 0, no sample tick occurs, and the sample period counter is held at its start. A threshold write also restarts the period, so the first tick after the write comes SAMPLE_DIV clocks after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Supply detector and sample timer enable |
| wake_en | input | 1 | Wake timer event enable |
| fifo_en | input | 1 | FIFO almost-empty event enable |
| thr_wr | input | 1 | Threshold code write strobe |
| thr_wdata | input | 4 | Threshold code to write |
| sup_below | input | 1 | Comparator result, 1 = supply below trip point (asynchronous) |
| wake_evt | input | 1 | Wake timer timeout pulse |
| fifo_evt | input | 1 | Transmit FIFO almost-empty pulse |
| stat_rd_done | input | 1 | Status read completed strobe |
| irq_n | output | 1 | Active-low interrupt request |
| thr_code | output | 4 | Current threshold code to the comparator |
| status | output | 4 | {sampled level, fifo, low supply, wake} |

## Verification
The comparator input is driven several ways:
- held high across several periods, which separates once-per-tick flagging from continuous flagging;
- pulsed briefly between ticks, which shows that only ticks are seen;
- left high across a clear, which shows re-flagging waits for the next tick.

Event pulses arrive with their enables both on and off, and some coincide with the clear strobe, which separates "ignored" from "lost" and confirms that set wins. A long random phase toggles enables, threshold writes and the detector enable, and a behavioural model is compared with the design on every clock. That phase exposes period restarts and any wrong release of irq_n.

// File: rtl/evtc_pkg.sv
package evtc_pkg;
    localparam int THR_W  = 4;
    localparam int STAT_W = 4;
    localparam int NSRC   = 3;

    localparam int SRC_WAKE = 0;
    localparam int SRC_LOW  = 1;
    localparam int SRC_FIFO = 2;

    typedef logic [NSRC-1:0] cause_t;
endpackage

// File: rtl/evtc_sync.sv
module evtc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/evtc_sample_timer.sv
module evtc_sample_timer #(
    parameter int SAMPLE_DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (SAMPLE_DIV > 2) ? $clog2(SAMPLE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(SAMPLE_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!run_i || restart_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            tick     = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = tick;

    // R3: ticks are never back to back
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    // R9: stopping or restarting the period suppresses the next tick
    a_r9_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i || restart_i) |=> !tick_o);
endmodule

// File: rtl/evtc_cause_reg.sv
module evtc_cause_reg
    import evtc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick_i,
    input  logic   level_i,
    input  logic   wake_i,
    input  logic   fifo_i,
    input  logic   wake_en_i,
    input  logic   fifo_en_i,
    input  logic   clear_i,
    output cause_t cause_o,
    output logic   sample_o
);
    typedef struct packed {
        cause_t cause;
        logic   sample;
    } cz_st_t;

    cz_st_t st_d, st_q;
    cause_t set_v;

    always_comb begin
        set_v           = '0;
        set_v[SRC_WAKE] = wake_i && wake_en_i;
        set_v[SRC_FIFO] = fifo_i && fifo_en_i;
        set_v[SRC_LOW]  = tick_i && level_i;
    end

    always_comb begin
        st_d = st_q;
        if (tick_i) st_d.sample = level_i;
        for (int i = 0; i < NSRC; i++) begin
            st_d.cause[i] = (st_q.cause[i] && !clear_i) || set_v[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o  = st_q.cause;
    assign sample_o = st_q.sample;

    // R4: the low-supply bit rises only after a tick that saw a low level
    a_r4_low_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o[SRC_LOW] && !$past(cause_o[SRC_LOW])) |-> $past(tick_i && level_i));
    // R7: a clear with no competing event empties every cause bit
    a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !wake_i && !fifo_i && !tick_i) |=> (cause_o == '0));
    // R7: bits hold until cleared
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o[SRC_WAKE] && !clear_i) |=> cause_o[SRC_WAKE]);
endmodule

// File: rtl/evtc_top.sv
module evtc_top
    import evtc_pkg::*;
#(
    parameter int SAMPLE_DIV = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_en,
    input  logic             wake_en,
    input  logic             fifo_en,
    input  logic             thr_wr,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             sup_below,
    input  logic             wake_evt,
    input  logic             fifo_evt,
    input  logic             stat_rd_done,
    output logic             irq_n,
    output logic [THR_W-1:0] thr_code,
    output logic [STAT_W-1:0] status
);
    typedef struct packed {
        logic [THR_W-1:0] thr;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    level_s;
    logic    tick;
    cause_t  cause;
    logic    sample;
    cause_t  en_v;

    always_comb begin
        st_d = st_q;
        if (thr_wr) st_d.thr = thr_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    evtc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sup_below),
        .q_o   (level_s)
    );

    evtc_sample_timer #(.SAMPLE_DIV(SAMPLE_DIV)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (det_en),
        .restart_i (thr_wr),
        .tick_o    (tick)
    );

    evtc_cause_reg u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .level_i   (level_s),
        .wake_i    (wake_evt),
        .fifo_i    (fifo_evt),
        .wake_en_i (wake_en),
        .fifo_en_i (fifo_en),
        .clear_i   (stat_rd_done),
        .cause_o   (cause),
        .sample_o  (sample)
    );

    always_comb begin
        en_v           = '0;
        en_v[SRC_WAKE] = wake_en;
        en_v[SRC_LOW]  = det_en;
        en_v[SRC_FIFO] = fifo_en;
    end

    assign irq_n    = ~|(cause & en_v);
    assign thr_code = st_q.thr;
    assign status   = {sample, cause};

    // R2: a write shows on the code output after its edge
    a_r2_thr_load: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (thr_code == $past(thr_wdata)));
    // R2: the code holds without a write
    a_r2_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_wr |=> $stable(thr_code));
    // R8: a request always has a readable cause
    a_r8_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (status[NSRC-1:0] != '0));
endmodule

// File: tb/tb_evtc_top.sv
`timescale 1ns/1ps
module tb_evtc_top;
    localparam int DIV = 8;
    localparam real TCK = 4.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic det_en = 0, wake_en = 0, fifo_en = 0, thr_wr = 0;
    logic [3:0] thr_wdata = 0;
    logic sup_below = 0, wake_evt = 0, fifo_evt = 0, stat_rd_done = 0;
    logic irq_n;
    logic [3:0] thr_code;
    logic [3:0] status;

    int n_tests = 0;
    int n_fail = 0;

    always #(TCK/2) clk = ~clk;

    evtc_top #(.SAMPLE_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .wake_en(wake_en),
        .fifo_en(fifo_en), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
        .sup_below(sup_below), .wake_evt(wake_evt), .fifo_evt(fifo_evt),
        .stat_rd_done(stat_rd_done), .irq_n(irq_n), .thr_code(thr_code),
        .status(status)
    );

    // behavioural reference model
    int  m_cnt = 0;
    bit  m_pipe[$] = '{0, 0};
    bit  m_wake = 0, m_low = 0, m_fifo = 0, m_samp = 0;
    int  m_thr = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_pipe = '{0, 0};
            m_wake = 0; m_low = 0; m_fifo = 0; m_samp = 0; m_thr = 0;
        end else begin
            bit lvl, tk;
            lvl = m_pipe[0];
            tk  = det_en && !thr_wr && (m_cnt == DIV - 1);
            if (!det_en || thr_wr) m_cnt = 0;
            else m_cnt = (m_cnt + 1) % DIV;
            if (stat_rd_done) begin m_wake = 0; m_low = 0; m_fifo = 0; end
            if (wake_en && wake_evt) m_wake = 1;
            if (fifo_en && fifo_evt) m_fifo = 1;
            if (tk) begin m_samp = lvl; if (lvl) m_low = 1; end
            void'(m_pipe.pop_front());
            m_pipe.push_back(sup_below);
            if (thr_wr) m_thr = thr_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison, between edges
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            bit eirq;
            eirq = !((m_wake && wake_en) || (m_low && det_en) || (m_fifo && fifo_en));
            chk(irq_n == eirq, "R8 irq_n", irq_n, eirq);
            chk(status[0] == m_wake, "R6 wake bit", status[0], m_wake);
            chk(status[1] == m_low,  "R4 low bit",  status[1], m_low);
            chk(status[2] == m_fifo, "R6 fifo bit", status[2], m_fifo);
            chk(status[3] == m_samp, "R3 sampled level", status[3], m_samp);
            chk(thr_code == m_thr[3:0], "R2 thr_code", thr_code, m_thr);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk); stat_rd_done = 1;
        @(negedge clk); stat_rd_done = 0;
    endtask

    initial begin
        #(TCK * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        #1;
        chk(irq_n == 1'b1, "R1 irq_n reset", irq_n, 1);
        chk(status == 4'd0, "R1 status reset", status, 0);
        chk(thr_code == 4'd0, "R1 thr reset", thr_code, 0);
        @(negedge clk); rst_n = 1;

        // R3/R4: detector on, supply fine
        det_en = 1; cyc(3 * DIV);
        chk(status[1] == 0, "R4 no flag when supply ok", status[1], 0);

        // R2 write, R9 restart
        @(negedge clk); thr_wr = 1; thr_wdata = 4'd9;
        @(negedge clk); thr_wr = 0;
        #1 chk(thr_code == 4'd9, "R2 code loaded", thr_code, 9);

        // R4: short pulse between ticks, placed right after the restart
        sup_below = 1; cyc(1); sup_below = 0; cyc(3 * DIV);
        chk(status[1] == 0, "R4 pulse between ticks ignored", status[1], 0);

        // R4 steady low
        sup_below = 1; cyc(3 * DIV);
        chk(status[1] == 1, "R4 steady low flagged", status[1], 1);
        chk(irq_n == 0, "R8 irq on low", irq_n, 0);

        // R5 re-flag after clear only at next tick
        pulse_rd(); #1;
        chk(status[1] == 0, "R5 cleared", status[1], 0);
        cyc(DIV + 2);
        chk(status[1] == 1, "R5 re-flagged at next tick", status[1], 1);
        sup_below = 0; cyc(2 * DIV); pulse_rd();

        // R6 disabled sources ignored
        @(negedge clk); wake_evt = 1; fifo_evt = 1;
        @(negedge clk); wake_evt = 0; fifo_evt = 0; #1;
        chk(status[2:0] == 3'b000, "R6 disabled events ignored", status, 0);
        chk(irq_n == 1, "R6 no request", irq_n, 1);
        wake_en = 1; fifo_en = 1;
        @(negedge clk); wake_evt = 1;
        @(negedge clk); wake_evt = 0; #1;
        chk(status[0] == 1, "R6 wake set", status[0], 1);

        // R7 sticky and set wins
        cyc(5); #1;
        chk(status[0] == 1, "R7 sticky", status[0], 1);
        @(negedge clk); stat_rd_done = 1; fifo_evt = 1;
        @(negedge clk); stat_rd_done = 0; fifo_evt = 0; #1;
        chk(status[2:0] == 3'b100, "R7 set wins over clear", status[2:0], 4);

        // R8 dropping enable releases irq
        @(negedge clk); fifo_en = 0; #1;
        chk(irq_n == 1, "R8 release on disable", irq_n, 1);
        chk(status[2] == 1, "R8 bit still readable", status[2], 1);
        pulse_rd();

        // R9 detector off
        det_en = 0; sup_below = 1; cyc(4 * DIV); #1;
        chk(status[1] == 0, "R9 no flag while disabled", status[1], 0);
        sup_below = 0; det_en = 1;

        // random phase
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            det_en       = ($urandom_range(0, 15) != 0);
            wake_en      = $urandom_range(0, 1);
            fifo_en      = $urandom_range(0, 1);
            thr_wr       = ($urandom_range(0, 40) == 0);
            thr_wdata    = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 5) == 0) sup_below = ~sup_below;
            wake_evt     = ($urandom_range(0, 20) == 0);
            fifo_evt     = ($urandom_range(0, 20) == 0);
            stat_rd_done = ($urandom_range(0, 12) == 0);
        end
        @(negedge clk);
        cyc(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule